// File: doc/BRIEF.md
# Dual-Address DMA Channel with Device-Driven Early Termination

This block is one DMA channel working in dual-address mode. For every operand it runs a read bus cycle at the source pointer, holds the returned data, and then runs a write bus cycle with that data at the destination pointer. After each write both pointers move forward by the operand size and the byte counter drops by the same amount. The transfer ends normally when the counter reaches zero. The attached device can also end it early by pulling the active-low `done_n` input.

Each bus cycle has three phases, and each phase lasts one clock. The address phase covers S0 and S1. The strobe phase covers S2 and S3. It repeats as a wait state while `bus_ack` is low, and `bus_ack` is sampled at its closing edge. The end phase covers S4 and S5. On a write, `done_n` is looked at on the same edge that accepts the acknowledge. On a read it is looked at one clock later, at the end-phase edge. The `done_direct` input chooses between sampling `done_n` as it is and sampling it after a one-flop synchroniser. The synchroniser costs one clock of advance notice.

The controller has these states: `ST_IDLE`, `ST_RD_A`, `ST_RD_S`, `ST_RD_E`, `ST_WR_A`, `ST_WR_S`, `ST_WR_E` and `ST_FIN`. Its transitions are as follows:
- IDLE to RD_A on an accepted start.
- RD_A to RD_S, and RD_S to RD_E on acknowledge.
- RD_E to WR_A, recording a termination if done is seen.
- WR_A to WR_S, and WR_S to WR_E on acknowledge, recording a termination if done is seen.
- WR_E to FIN when a termination was recorded or the counter runs out.
- WR_E to IDLE when the run bit has been cleared (suspend).
- WR_E to RD_A otherwise.
- FIN to IDLE when the status flag is cleared.

Top module: `dma_xt_channel`

## Requirements
- R1: After reset the channel is idle: `bus_rd`, `bus_wr`, `bus_strb`, `running`, `status` and `irq` are all 0.
- R2: A `run_set` pulse starts a transfer only while the channel is idle, `status` is 0 and the counter is non-zero. Otherwise it is ignored and no bus cycle follows.
- R3: Each operand is a read at the source pointer followed by a write of the same data at the destination pointer. The strobe phase repeats while `bus_ack` is low.
- R4: Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. After each write both pointers advance by that step. The counter drops by the step and stops at 0.
- R5: When the counter reaches 0 the channel stops. `running` goes to 0 and `status` goes to 1.
- R6: `irq` equals `status` gated by `irq_en`. Both stay high until a `stat_clr` pulse, which clears `status` and lets a new start be accepted.
- R7: If done is recognised on a read cycle, the matching write still completes and then the channel finishes.
- R8: If done is recognised on a write cycle, no further bus cycle is started and the channel finishes.
- R9: With `done_direct`=1, done counts only if `done_n` is low at the sample edge. A pulse that is low only during the read strobe clock is ignored.
- R10: With `done_direct`=0, `done_n` must be low at the edge one clock before the sample edge. A pulse present only at the sample edge is ignored.
- R11: Wait states move the write sample point. A direct done pulse during a strobe clock without acknowledge is ignored.
- R12: Clearing the run bit suspends the channel after the current operand's write, with `status` left at 0. A new `run_set` resumes from the current pointers and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load pointers, counter and size (accepted only in IDLE) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Byte count |
| cfg_size | input | 2 | Operand size code |
| done_direct | input | 1 | 1: sample done directly, 0: through the synchroniser |
| irq_en | input | 1 | Interrupt mask bit |
| run_set | input | 1 | Start or resume pulse |
| run_clr | input | 1 | Suspend pulse |
| stat_clr | input | 1 | Clear the status flag |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| bus_strb | output | 1 | Strobe phase |
| bus_size | output | 2 | Operand size code of the cycle |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Cycle acknowledge |
| done_n | input | 1 | Active-low external done |
| running | output | 1 | Run bit |
| status | output | 1 | Transfer-finished flag |
| irq | output | 1 | Done interrupt |
| cur_src | output | AW | Current source pointer |
| cur_dst | output | AW | Current destination pointer |
| cur_cnt | output | CW | Current byte count |

## Verification
An external done and counter exhaustion can both end the transfer on the same write. To provoke this, a vector asserts done on the write of the last operand, so the recorded termination and the last-operand condition reach `ST_WR_E` together. The check then confirms that exactly the expected number of writes appeared, that the counter is 0 with no wrap, and that `status` rose once and stays high with `running` low. A suspend request that lands in the middle of an operand is also checked: it must let that operand's write finish and must not set `status`.

// File: rtl/dma_xt_pkg.sv
package dma_xt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_S,
        ST_RD_E,
        ST_WR_A,
        ST_WR_S,
        ST_WR_E,
        ST_FIN
    } chan_state_t;

    // operand size code -> byte step
    function automatic logic [2:0] size_to_step(input logic [1:0] code);
        logic [2:0] s;
        unique case (code)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_xt_done_sampler.sv
module dma_xt_done_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic done_n,
    input  logic direct,
    output logic done_seen
);

    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= ~done_n;
        end
    end

    always_comb begin
        done_seen = direct ? ~done_n : sync_q;
    end

    // R10: synchronised path reports only what was present one edge earlier
    a_r10_sync_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && done_seen) |-> $past(~done_n));

endmodule

// File: rtl/dma_xt_ptr_unit.sv
module dma_xt_ptr_unit #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_src,
    input  logic [AW-1:0] load_dst,
    input  logic [CW-1:0] load_cnt,
    input  logic [2:0]    step,
    input  logic          adv,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          last_op,
    output logic          cnt_nz
);

    logic [CW-1:0] step_c;

    always_comb begin
        step_c  = CW'(step);
        last_op = (cnt <= step_c);
        cnt_nz  = |cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else if (load) begin
            src <= load_src;
            dst <= load_dst;
            cnt <= load_cnt;
        end else if (adv) begin
            src <= src + AW'(step);
            dst <= dst + AW'(step);
            cnt <= (cnt > step_c) ? (cnt - step_c) : '0;
        end
    end

    // R4: pointer moves by exactly one step per completed operand
    a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (src == $past(src) + AW'($past(step))));

    // R4: counter never wraps below zero on the final operand
    a_r4_cnt_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && last_op) |=> (cnt == '0));

endmodule

// File: rtl/dma_xt_fsm.sv
module dma_xt_fsm
    import dma_xt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        run_ok,
    input  logic        stat_clr,
    input  logic        bus_ack,
    input  logic        done_seen,
    input  logic        last_op,
    output chan_state_t state,
    output logic        adv,
    output logic        capture,
    output logic        finish
);

    chan_state_t nxt;
    logic        term_q;
    logic        term_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            term_q <= 1'b0;
        end else begin
            state  <= nxt;
            term_q <= term_d;
        end
    end

    always_comb begin
        nxt    = state;
        term_d = term_q;
        unique case (state)
            ST_IDLE: begin
                term_d = 1'b0;
                if (start) nxt = ST_RD_A;
            end
            ST_RD_A: nxt = ST_RD_S;
            ST_RD_S: if (bus_ack) nxt = ST_RD_E;
            ST_RD_E: begin
                if (done_seen) term_d = 1'b1;
                nxt = ST_WR_A;
            end
            ST_WR_A: nxt = ST_WR_S;
            ST_WR_S: begin
                if (bus_ack) begin
                    nxt = ST_WR_E;
                    if (done_seen) term_d = 1'b1;
                end
            end
            ST_WR_E: begin
                if (term_q || last_op) begin
                    nxt    = ST_FIN;
                    term_d = 1'b0;
                end else if (!run_ok) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt = ST_RD_A;
                end
            end
            ST_FIN: if (stat_clr) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        adv     = (state == ST_WR_E);
        capture = (state == ST_RD_S) && bus_ack;
        finish  = (state == ST_WR_E) && (term_q || last_op);
    end

    // R3: strobe phase is held while acknowledge stays low
    a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_S && !bus_ack) |=> (state == ST_RD_S));

    // R7: done on the read end phase still lets the write run
    a_r7_read_done_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_E && done_seen) |=> (state == ST_WR_A && term_q));

    // R8: done on the write acknowledge starts no further cycle
    a_r8_write_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_S && bus_ack && done_seen) |=> ##1 (state == ST_FIN));

    // R6: finished state is left only through a status clear
    a_r6_fin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN && !stat_clr) |=> (state == ST_FIN));

endmodule

// File: rtl/dma_xt_channel.sv
module dma_xt_channel
    import dma_xt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [1:0]    cfg_size,
    input  logic          done_direct,
    input  logic          irq_en,
    input  logic          run_set,
    input  logic          run_clr,
    input  logic          stat_clr,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_strb,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          done_n,
    output logic          running,
    output logic          status,
    output logic          irq,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt
);

    chan_state_t   state;
    logic          run_q;
    logic          status_q;
    logic [1:0]    size_q;
    logic [DW-1:0] hold_q;
    logic          done_seen;
    logic          adv;
    logic          capture;
    logic          finish;
    logic          last_op;
    logic          cnt_nz;
    logic          start;
    logic          run_ok;
    logic          load_ok;
    logic [2:0]    step;

    always_comb begin
        load_ok = cfg_load && (state == ST_IDLE);
        start   = (state == ST_IDLE) && run_set && !status_q && cnt_nz;
        run_ok  = run_q && !run_clr;
        step    = size_to_step(size_q);
    end

    dma_xt_done_sampler u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_n    (done_n),
        .direct    (done_direct),
        .done_seen (done_seen)
    );

    dma_xt_ptr_unit #(.AW(AW), .CW(CW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_src (cfg_src),
        .load_dst (cfg_dst),
        .load_cnt (cfg_cnt),
        .step     (step),
        .adv      (adv),
        .src      (cur_src),
        .dst      (cur_dst),
        .cnt      (cur_cnt),
        .last_op  (last_op),
        .cnt_nz   (cnt_nz)
    );

    dma_xt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run_ok    (run_ok),
        .stat_clr  (stat_clr),
        .bus_ack   (bus_ack),
        .done_seen (done_seen),
        .last_op   (last_op),
        .state     (state),
        .adv       (adv),
        .capture   (capture),
        .finish    (finish)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            status_q <= 1'b0;
            size_q   <= 2'd0;
            hold_q   <= '0;
        end else begin
            if (finish)        run_q <= 1'b0;
            else if (run_clr)  run_q <= 1'b0;
            else if (start)    run_q <= 1'b1;

            if (finish)                                status_q <= 1'b1;
            else if (stat_clr && state == ST_FIN)      status_q <= 1'b0;

            if (load_ok) size_q <= cfg_size;
            if (capture) hold_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_rd    = (state == ST_RD_A) || (state == ST_RD_S) || (state == ST_RD_E);
        bus_wr    = (state == ST_WR_A) || (state == ST_WR_S) || (state == ST_WR_E);
        bus_strb  = (state == ST_RD_S) || (state == ST_WR_S);
        bus_addr  = bus_rd ? cur_src : (bus_wr ? cur_dst : '0);
        bus_size  = size_q;
        bus_wdata = hold_q;
        running   = run_q;
        status    = status_q;
        irq       = status_q && irq_en;
    end

    // R3: a cycle is either a read or a write, never both
    a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5: the run bit is down whenever the finished flag rises
    a_r5_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> !run_q);

    // R6: the finished flag only falls after a clear request
    a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q) |-> $past(stat_clr));

endmodule

// File: tb/dma_xt_channel_tb.sv
module dma_xt_channel_tb;

    typedef struct packed {
        logic [1:0]  size;
        logic [15:0] cnt;
        logic [3:0]  waits;
        logic [2:0]  dsel;   // 0 none,1 read cycle,2 write cycle,3 write ack pulse,4 read ack pulse,5 write non-ack pulse
        logic [7:0]  dop;
        logic        direct;
        logic        irqen;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd4,  4'd0, 3'd0, 8'd0, 1'b0, 1'b1},
        '{2'd1, 16'd6,  4'd1, 3'd0, 8'd0, 1'b0, 1'b0},
        '{2'd2, 16'd10, 4'd0, 3'd0, 8'd0, 1'b1, 1'b1},
        '{2'd0, 16'd8,  4'd2, 3'd1, 8'd2, 1'b1, 1'b1},
        '{2'd0, 16'd8,  4'd0, 3'd2, 8'd1, 1'b0, 1'b0},
        '{2'd1, 16'd8,  4'd1, 3'd3, 8'd1, 1'b1, 1'b1},
        '{2'd1, 16'd8,  4'd1, 3'd3, 8'd1, 1'b0, 1'b1},
        '{2'd0, 16'd6,  4'd0, 3'd4, 8'd2, 1'b0, 1'b0},
        '{2'd0, 16'd6,  4'd0, 3'd4, 8'd2, 1'b1, 1'b1},
        '{2'd0, 16'd5,  4'd2, 3'd5, 8'd1, 1'b1, 1'b0},
        '{2'd2, 16'd8,  4'd0, 3'd2, 8'd1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_src = '0;
    logic [31:0] cfg_dst = '0;
    logic [15:0] cfg_cnt = '0;
    logic [1:0]  cfg_size = '0;
    logic        done_direct = 1'b0;
    logic        irq_en = 1'b0;
    logic        run_set = 1'b0;
    logic        run_clr = 1'b0;
    logic        stat_clr = 1'b0;
    logic [31:0] bus_addr;
    logic        bus_rd, bus_wr, bus_strb;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        done_n = 1'b1;
    logic        running, status, irq;
    logic [31:0] cur_src, cur_dst;
    logic [15:0] cur_cnt;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    int t_waits = 0;
    int t_dsel = 0;
    int t_dop = 0;
    int wcnt = 0;
    int op_idx = 0;
    int nw = 0;
    bit bus_seen = 0;
    logic [31:0] wlog_addr [64];
    logic [31:0] wlog_data [64];

    always #5 clk = ~clk;

    dma_xt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_size(cfg_size),
        .done_direct(done_direct), .irq_en(irq_en), .run_set(run_set),
        .run_clr(run_clr), .stat_clr(stat_clr), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_strb(bus_strb),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .done_n(done_n), .running(running),
        .status(status), .irq(irq), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_cnt(cur_cnt)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // slave model: acts on the falling edge
    always @(negedge clk) begin
        logic a;
        logic dn;
        if (!rst_n) begin
            wcnt = 0;
            bus_ack = 1'b0;
            done_n = 1'b1;
        end else begin
            a = bus_strb && (wcnt >= t_waits);
            if (bus_strb) wcnt = a ? 0 : wcnt + 1;
            else          wcnt = 0;
            dn = 1'b0;
            case (t_dsel)
                1: dn = bus_rd && (op_idx == t_dop);
                2: dn = bus_wr && (op_idx == t_dop);
                3: dn = bus_wr && a && (op_idx == t_dop);
                4: dn = bus_rd && a && (op_idx == t_dop);
                5: dn = bus_wr && bus_strb && !a && (op_idx == t_dop);
                default: dn = 1'b0;
            endcase
            bus_ack   = a;
            done_n    = ~dn;
            bus_rdata = pat(bus_addr);
            if (bus_rd || bus_wr) bus_seen = 1;
            if (bus_wr && a) begin
                if (nw < 64) begin
                    wlog_addr[nw] = bus_addr;
                    wlog_data[nw] = bus_wdata;
                end
                nw = nw + 1;
                op_idx = op_idx + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic configure(input logic [31:0] s, input logic [31:0] d,
                             input logic [15:0] c, input logic [1:0] z);
        cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_size = z;
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic pulse_run();
        run_set = 1'b1;
        tick();
        run_set = 1'b0;
    endtask

    task automatic wait_status();
        for (int k = 0; k < 3000 && status !== 1'b1; k++) tick();
    endtask

    task automatic clear_status();
        stat_clr = 1'b1;
        tick();
        stat_clr = 1'b0;
        tick();
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] s0;
        logic [31:0] d0;
        int step;
        int full;
        int ops;
        int rem;
        bit rec;
        string rq;
        s0 = 32'h0001_0000 + idx * 32'h100;
        d0 = 32'h0008_0000 + idx * 32'h100;
        step = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
        full = (int'(v.cnt) + step - 1) / step;
        case (v.dsel)
            3'd1, 3'd2: rec = 1;
            3'd3:       rec = v.direct;
            3'd4:       rec = !v.direct;
            default:    rec = 0;
        endcase
        ops = rec ? int'(v.dop) + 1 : full;
        if (ops > full) ops = full;
        rem = int'(v.cnt) - ops * step;
        if (rem < 0) rem = 0;
        case (v.dsel)
            3'd1: rq = "R7";
            3'd2: rq = "R8";
            3'd3: rq = v.direct ? "R9" : "R10";
            3'd4: rq = v.direct ? "R9" : "R10";
            3'd5: rq = "R11";
            default: rq = "R5";
        endcase

        t_waits = int'(v.waits); t_dsel = int'(v.dsel); t_dop = int'(v.dop);
        nw = 0; op_idx = 0;
        done_direct = v.direct; irq_en = v.irqen;
        configure(s0, d0, v.cnt, v.size);
        pulse_run();
        wait_status();

        chk(rq, "write count", 64'(nw), 64'(ops));
        for (int i = 0; i < ops && i < 64 && i < nw; i++) begin
            chk("R3", "write addr", 64'(wlog_addr[i]), 64'(d0 + 32'(i * step)));
            chk("R3", "write data", 64'(wlog_data[i]), 64'(pat(s0 + 32'(i * step))));
        end
        chk("R4", "src pointer", 64'(cur_src), 64'(s0 + 32'(ops * step)));
        chk("R4", "dst pointer", 64'(cur_dst), 64'(d0 + 32'(ops * step)));
        chk("R4", "count", 64'(cur_cnt), 64'(rem));
        chk("R5", "running", 64'(running), 64'd0);
        chk("R5", "status", 64'(status), 64'd1);
        chk("R6", "irq", 64'(irq), 64'(v.irqen));

        // R2: start ignored while status is set
        bus_seen = 0;
        pulse_run();
        for (int k = 0; k < 8; k++) tick();
        chk("R2", "bus idle with status set", 64'(bus_seen), 64'd0);
        chk("R2", "count held", 64'(cur_cnt), 64'(rem));

        clear_status();
        chk("R6", "status cleared", 64'(status), 64'd0);
        chk("R6", "irq cleared", 64'(irq), 64'd0);
        t_dsel = 0;
    endtask

    initial begin
        // R1 reset state
        for (int k = 0; k < 3; k++) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "bus_rd", 64'(bus_rd), 64'd0);
        chk("R1", "bus_wr", 64'(bus_wr), 64'd0);
        chk("R1", "bus_strb", 64'(bus_strb), 64'd0);
        chk("R1", "running", 64'(running), 64'd0);
        chk("R1", "status", 64'(status), 64'd0);
        chk("R1", "irq", 64'(irq), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R2: zero count start is ignored
        t_dsel = 0; t_waits = 0;
        configure(32'h0004_0000, 32'h0005_0000, 16'd0, 2'd0);
        bus_seen = 0;
        pulse_run();
        for (int k = 0; k < 8; k++) tick();
        chk("R2", "zero count no bus", 64'(bus_seen), 64'd0);
        chk("R2", "zero count not running", 64'(running), 64'd0);

        // R12: suspend mid-operand, then resume
        nw = 0; op_idx = 0; done_direct = 1'b1; irq_en = 1'b1;
        configure(32'h0006_0000, 32'h0007_0000, 16'd6, 2'd0);
        pulse_run();
        for (int k = 0; k < 200 && nw < 1; k++) tick();
        tick();
        tick();
        run_clr = 1'b1;
        tick();
        run_clr = 1'b0;
        for (int k = 0; k < 15; k++) tick();
        chk("R12", "writes before suspend", 64'(nw), 64'd2);
        chk("R12", "count at suspend", 64'(cur_cnt), 64'd4);
        chk("R12", "status on suspend", 64'(status), 64'd0);
        chk("R12", "running on suspend", 64'(running), 64'd0);
        pulse_run();
        wait_status();
        chk("R12", "writes after resume", 64'(nw), 64'd6);
        chk("R12", "last write addr", 64'(wlog_addr[5]), 64'h0007_0005);
        chk("R12", "last write data", 64'(wlog_data[5]), 64'(pat(32'h0006_0005)));
        chk("R12", "count after resume", 64'(cur_cnt), 64'd0);
        clear_status();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule